// File: doc/BRIEF.md
# Byte-Stepping Opcode Core

This block is a very small 8-bit processor core. It reads one-byte opcodes through a synchronous byte-wide read port, addressed by a 16-bit program counter. It runs a fixed set of four instructions:

- a no-operation;
- an accumulator increment that updates the flags;
- an absolute jump whose 16-bit target follows the opcode as two operand bytes;
- a jump to the address held in the H:L register pair.

Any other byte is a trap: the core stops, raises `halted`, and stays there until reset.

The architectural state is driven straight out on ports so that a surrounding environment can compare it with a model after each instruction. This state is the accumulator, the flag byte, the B, C, H and L registers and the program counter. The memory port has one cycle of latency: an address presented with `mem_rd` high at one clock edge returns its byte on `mem_rdata` during the following cycle.

Top module: `byte_step_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears the program counter, accumulator, flags and the B, C, H and L registers to zero, and deasserts `halted`.
- R2: The flag byte holds carry at bit 4, half-carry at bit 5, subtract at bit 6 and zero at bit 7, and bits 3..0 always read zero.
- R3: Opcode 0x00 takes 2 cycles, advances the program counter by one and leaves every other register unchanged.
- R4: Opcode 0x3C takes 2 cycles and adds one to the accumulator, wrapping 0xFF to 0x00; it sets the zero flag (bit 7) exactly when the new accumulator is 0x00.
- R5: Opcode 0x3C clears the subtract flag (bit 6) and leaves the carry flag (bit 4) at its previous value.
- R6: Opcode 0x3C sets the half-carry flag (bit 5) exactly when the low four bits of the new accumulator are zero, and clears it otherwise.
- R7: Opcode 0xC3 takes 4 cycles and reads the low target byte from opcode address + 1, then the high byte from opcode address + 2; the program counter then becomes high:low.
- R8: Opcode 0xE9 takes 2 cycles and loads the program counter with H as the upper byte and L as the lower byte.
- R9: Any other opcode sets `halted` 2 cycles after its fetch, with the program counter one past the opcode; from then on the core holds `mem_rd` low and keeps its state until reset.
- R10: Each instruction begins with a read at the current program counter, with `mem_rd` high, and the program counter grows by one at the edge that issues that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Read address, equal to the program counter |
| mem_rd | output | 1 | Read strobe; data returns in the next cycle |
| mem_rdata | input | 8 | Byte returned one cycle after a read |
| halted | output | 1 | High after an undefined opcode until reset |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Flag byte (Z bit 7, N bit 6, H bit 5, C bit 4) |
| b_o | output | 8 | B register |
| c_o | output | 8 | C register |
| h_o | output | 8 | H register |
| l_o | output | 8 | L register |

## Verification
The assertions assume that the memory answers every read with a byte in the very next cycle and never returns unknowns. They also assume that `rst` is held for at least one edge before the core runs. The bench keeps to this with a 256-byte array that latches its output on every edge where `mem_rd` is high. Addresses alias modulo 256, so every jump target is a valid location. Random programs draw mostly from the four defined opcodes, with occasional stray bytes, so that traps are reached without cutting runs too short.

// File: rtl/step_core_pkg.sv
`timescale 1ns/1ps
package step_core_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  localparam int FLG_C = 4;
  localparam int FLG_H = 5;
  localparam int FLG_N = 6;
  localparam int FLG_Z = 7;

  localparam logic [DW-1:0] OP_NOP   = 8'h00;
  localparam logic [DW-1:0] OP_INCA  = 8'h3C;
  localparam logic [DW-1:0] OP_JPIMM = 8'hC3;
  localparam logic [DW-1:0] OP_JPHL  = 8'hE9;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_OPLO   = 3'd2,
    ST_OPHI   = 3'd3,
    ST_HALT   = 3'd4
  } step_state_e;

  typedef struct packed {
    logic [DW-1:0] acc;
    logic [DW-1:0] flg;
  } inc_res_t;

  // Increment with flag update: Z, H from the result, N cleared, C kept.
  function automatic inc_res_t inc_acc(input logic [DW-1:0] a,
                                       input logic [DW-1:0] f);
    inc_res_t r;
    r.acc        = a + 1'b1;
    r.flg        = '0;
    r.flg[FLG_C] = f[FLG_C];
    r.flg[FLG_N] = 1'b0;
    r.flg[FLG_H] = (r.acc[3:0] == 4'h0);
    r.flg[FLG_Z] = (r.acc == '0);
    return r;
  endfunction
endpackage

// File: rtl/core_alu.sv
`timescale 1ns/1ps
module core_alu
  import step_core_pkg::*;
(
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] flg_in,
  output logic [DW-1:0] acc_out,
  output logic [DW-1:0] flg_out
);
  inc_res_t res;

  always_comb begin
    res     = inc_acc(acc_in, flg_in);
    acc_out = res.acc;
    flg_out = res.flg;
  end
endmodule

// File: rtl/core_regs.sv
`timescale 1ns/1ps
module core_regs
  import step_core_pkg::*;
#(
  parameter int NGP = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inc_we,
  input  logic [DW-1:0]           acc_nxt,
  input  logic [DW-1:0]           flg_nxt,
  output logic [DW-1:0]           acc_q,
  output logic [DW-1:0]           flg_q,
  output logic [NGP-1:0][DW-1:0]  gp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (inc_we) begin
      acc_q <= acc_nxt;
      flg_q <= flg_nxt;
    end
  end

  // General registers: cleared by reset, no instruction in the set writes them.
  for (genvar g = 0; g < NGP; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (rst) gp_q[g] <= '0;
    end
  end

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    inc_we |=> (acc_q == $past(acc_q) + 8'd1) && (flg_q[FLG_Z] == (acc_q == 8'h00)));

  assert_inc_nc_R5: assert property (@(posedge clk) disable iff (rst)
    inc_we |=> !flg_q[FLG_N] && (flg_q[FLG_C] == $past(flg_q[FLG_C])));

  assert_inc_half_R6: assert property (@(posedge clk) disable iff (rst)
    inc_we |=> (flg_q[FLG_H] == (acc_q[3:0] == 4'h0)));

  assert_hold_acc_R3: assert property (@(posedge clk) disable iff (rst)
    !inc_we |=> $stable(acc_q) && $stable(flg_q));

  assert_low_flags_R2: assert property (@(posedge clk) disable iff (rst)
    flg_q[3:0] == 4'h0);
endmodule

// File: rtl/core_seq.sv
`timescale 1ns/1ps
module core_seq
  import step_core_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] h_in,
  input  logic [DW-1:0] l_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic [AW-1:0] pc_q,
  output logic          halted,
  output logic          inc_we
);
  step_state_e   st_q;
  logic [DW-1:0] lo_q;

  // Named events for the assertions
  logic fetch_fire, jp_imm_fire, jp_hl_fire, trap_fire, opnd_rd;

  always_comb begin
    fetch_fire  = (st_q == ST_FETCH);
    jp_imm_fire = (st_q == ST_OPHI);
    inc_we      = (st_q == ST_DECODE) && (mem_rdata == OP_INCA);
    jp_hl_fire  = (st_q == ST_DECODE) && (mem_rdata == OP_JPHL);
    opnd_rd     = (st_q == ST_DECODE) && (mem_rdata == OP_JPIMM);
    trap_fire   = (st_q == ST_DECODE) && (mem_rdata != OP_NOP) && (mem_rdata != OP_INCA) &&
                  (mem_rdata != OP_JPIMM) && (mem_rdata != OP_JPHL);
    mem_rd      = fetch_fire || opnd_rd || (st_q == ST_OPLO);
    mem_addr    = pc_q;
    halted      = (st_q == ST_HALT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_FETCH;
      pc_q <= '0;
      lo_q <= '0;
    end else begin
      case (st_q)
        ST_FETCH: begin
          pc_q <= pc_q + 1'b1;
          st_q <= ST_DECODE;
        end
        ST_DECODE: begin
          case (mem_rdata)
            OP_NOP, OP_INCA: st_q <= ST_FETCH;
            OP_JPIMM: begin
              pc_q <= pc_q + 1'b1;
              st_q <= ST_OPLO;
            end
            OP_JPHL: begin
              pc_q <= {h_in, l_in};
              st_q <= ST_FETCH;
            end
            default: st_q <= ST_HALT;
          endcase
        end
        ST_OPLO: begin
          lo_q <= mem_rdata;
          st_q <= ST_OPHI;
        end
        ST_OPHI: begin
          pc_q <= {mem_rdata, lo_q};
          st_q <= ST_FETCH;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assert_fetch_inc_R10: assert property (@(posedge clk) disable iff (rst)
    fetch_fire |=> pc_q == $past(pc_q) + 16'd1);

  assert_jp_imm_R7: assert property (@(posedge clk) disable iff (rst)
    jp_imm_fire |=> pc_q == {$past(mem_rdata), $past(lo_q)});

  assert_jp_hl_R8: assert property (@(posedge clk) disable iff (rst)
    jp_hl_fire |=> pc_q == {$past(h_in), $past(l_in)});

  assert_trap_halts_R9: assert property (@(posedge clk) disable iff (rst)
    trap_fire |=> halted);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_rd);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc_q));
endmodule

// File: rtl/byte_step_core.sv
`timescale 1ns/1ps
module byte_step_core
  import step_core_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] flags_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] c_o,
  output logic [DW-1:0] h_o,
  output logic [DW-1:0] l_o
);
  localparam int NGP = 4;

  logic                   inc_we;
  logic [DW-1:0]          acc_nxt, flg_nxt, acc_q, flg_q;
  logic [NGP-1:0][DW-1:0] gp_q;

  core_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .mem_rdata(mem_rdata),
    .h_in     (gp_q[2]),
    .l_in     (gp_q[3]),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .pc_q     (pc_o),
    .halted   (halted),
    .inc_we   (inc_we)
  );

  core_alu u_alu (
    .acc_in (acc_q),
    .flg_in (flg_q),
    .acc_out(acc_nxt),
    .flg_out(flg_nxt)
  );

  core_regs #(.NGP(NGP)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .inc_we (inc_we),
    .acc_nxt(acc_nxt),
    .flg_nxt(flg_nxt),
    .acc_q  (acc_q),
    .flg_q  (flg_q),
    .gp_q   (gp_q)
  );

  assign acc_o   = acc_q;
  assign flags_o = flg_q;
  assign b_o     = gp_q[0];
  assign c_o     = gp_q[1];
  assign h_o     = gp_q[2];
  assign l_o     = gp_q[3];
endmodule

// File: tb/tb_byte_step_core.sv
`timescale 1ns/1ps
module tb_byte_step_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = 8'h00;
  logic        halted;
  logic [15:0] pc_o;
  logic [7:0]  acc_o, flags_o, b_o, c_o, h_o, l_o;

  logic [7:0] mem [256];

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_pc;
  logic [7:0]  m_a, m_f;
  logic        m_halt;

  always #4 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  byte_step_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .halted(halted), .pc_o(pc_o), .acc_o(acc_o), .flags_o(flags_o),
    .b_o(b_o), .c_o(c_o), .h_o(h_o), .l_o(l_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench restatement of the increment flags
  function automatic logic [7:0] flags_after_inc(input logic [7:0] new_a, input logic [7:0] old_f);
    logic [7:0] f;
    f = old_f & 8'h10;
    if (new_a == 8'h00) f = f | 8'h80;
    if ((new_a % 16) == 0) f = f | 8'h20;
    return f;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = 16'h0; m_a = 8'h0; m_f = 8'h0; m_halt = 1'b0;
    chk(pc_o == 16'h0 && acc_o == 8'h0 && flags_o == 8'h0 && !halted, "R1", "pc/acc/flags/halt",
        {pc_o, acc_o, flags_o}, 32'h0);
    chk({b_o, c_o, h_o, l_o} == 32'h0, "R1", "b/c/h/l", {b_o, c_o, h_o, l_o}, 32'h0);
  endtask

  // Runs one instruction from a fetch boundary (called at a negedge).
  task automatic step_one();
    logic [7:0]  op, lo, hi;
    logic [15:0] nxt;
    int          cyc;
    string       tag;
    chk(mem_rd && mem_addr == m_pc, "R10", "fetch addr", {15'h0, mem_rd, mem_addr}, {16'h1, m_pc});
    op  = mem[m_pc[7:0]];
    nxt = m_pc + 16'd1;
    case (op)
      8'h00: begin m_pc = nxt; cyc = 2; tag = "R3"; end
      8'h3C: begin
        m_a = m_a + 8'd1; m_f = flags_after_inc(m_a, m_f); m_pc = nxt; cyc = 2; tag = "R4 R5 R6";
      end
      8'hC3: begin
        lo = mem[nxt[7:0]]; hi = mem[8'(nxt[7:0] + 8'd1)];
        m_pc = {hi, lo}; cyc = 4; tag = "R7";
      end
      8'hE9: begin m_pc = {h_o, l_o}; cyc = 2; tag = "R8"; end
      default: begin m_pc = nxt; m_halt = 1'b1; cyc = 2; tag = "R9"; end
    endcase
    repeat (cyc) @(posedge clk);
    @(negedge clk);
    chk(pc_o == m_pc, tag, "pc", pc_o, m_pc);
    chk(acc_o == m_a, tag, "acc", acc_o, m_a);
    chk(flags_o == m_f, tag, "flags (R2 layout)", flags_o, m_f);
    chk(halted == m_halt, tag, "halted", halted, m_halt);
  endtask

  task automatic check_quiet();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!mem_rd && halted && pc_o == m_pc, "R9", "quiet after trap",
          {15'h0, mem_rd, pc_o}, {16'h0, m_pc});
    end
  endtask

  task automatic run(input int max_steps);
    for (int s = 0; s < max_steps && !m_halt; s++) step_one();
    if (m_halt) check_quiet();
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    int r;
    seed = 1234;
    r = $urandom(seed);

    // R4 R5 R6: long run of increments across the 0xFF wrap and nibble edges
    for (int i = 0; i < 256; i++) mem[i] = 8'h3C;
    do_reset();
    run(300);

    // R7 R8 R3: directed jumps, target 0x0150 aliases to byte 0x50
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[2] = 8'hC3; mem[3] = 8'h50; mem[4] = 8'h01;
    mem[8'h50] = 8'h3C; mem[8'h51] = 8'hE9;
    do_reset();
    run(12);

    // R9: trap after an increment
    mem[0] = 8'h3C; mem[1] = 8'h76;
    do_reset();
    run(5);
    chk(m_halt, "R9", "trap reached", {31'h0, m_halt}, 32'h1);

    // Random programs drawn mostly from the defined set
    for (int round = 0; round < 8; round++) begin
      for (int i = 0; i < 256; i++) begin
        r = $urandom % 32;
        if (r < 10) mem[i] = 8'h3C;
        else if (r < 18) mem[i] = 8'h00;
        else if (r < 22) mem[i] = 8'hC3;
        else if (r < 24) mem[i] = 8'hE9;
        else if (r < 25) mem[i] = 8'h01;
        else mem[i] = 8'($urandom);
      end
      do_reset();
      run(400);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule